// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts the direction and target of a branch from its fetch address. A 10-bit global history register records the outcomes of recent resolved branches. It indexes a table of 4096 two-bit saturating counters, laid out as 256 rows of 16 counters. A direct-mapped branch target buffer with 512 entries supplies the target and the type of a branch that has been seen before. A fetch stage offers a word address on the predict side and receives a direction, a target, a hit flag, a type and the number of fetch bubbles that a taken prediction costs. The execute stage reports each resolved branch on the update side. That report trains the counter, shifts the history and refreshes the target buffer entry.

A control state machine has two states. After reset it sits in SWEEP, which clears one counter row and one target buffer entry per cycle. It moves to RUN after 512 cycles, the size of the larger table, and stays in RUN until the next reset. The transitions are: reset→SWEEP, SWEEP→SWEEP while the sweep index is below its last value, SWEEP→RUN at the last index, and RUN→RUN. All addresses on the ports are word addresses, meaning the byte address shifted right by two. The mispredict penalty of 13 cycles is a parameter and is driven as a constant on a port, so the pipeline can read it.

Top module: `gbp_predictor`

## Requirements
- R1: For the first 512 cycles after reset is released (state SWEEP), every prediction output is zero. Update reports in those cycles change neither the counters, the history nor the target buffer.
- R2: Each accepted update shifts the resolved outcome into the history at bit 0, and the oldest bit falls off at bit 9. With no accepted update, the history holds. Its reset value is zero.
- R3: The counter for a lookup sits in row history[9:2] and column ({2'b00, history[1:0]} XOR wpc[3:0]). The predict side and the update side both use the history value current in that cycle.
- R4: Counters take the values 0 to 3. They start at 1 after the sweep, count up on a taken outcome and down on a not-taken outcome, and saturate at 3 and at 0. A value of 2 or 3 means taken.
- R5: The target buffer entry for a lookup is wpc[8:0], and its tag is wpc[29:9]. A hit needs a valid entry whose tag matches.
- R6: pred_taken is 1 only when the target buffer hits and the selected counter means taken. On a hit, pred_target and pred_type come from the entry. On a miss, both are zero.
- R7: pred_bubbles is 1 when pred_taken is 1, and 0 otherwise.
- R8: Every accepted update, taken or not, writes its tag, target and type into its target buffer entry and marks the entry valid. A lookup of the same address one cycle later hits.
- R9: When a predict and an update touch the same counter or entry in the same cycle, the prediction reflects the contents from before that update.
- R10: mispredict_penalty reads 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_wpc | input | 30 | Word address of the branch being fetched |
| pred_taken | output | 1 | Predicted taken |
| pred_btb_hit | output | 1 | Target buffer holds this address |
| pred_target | output | 30 | Predicted target word address, zero on miss |
| pred_type | output | 2 | Stored branch type, zero on miss |
| pred_bubbles | output | 2 | Fetch bubbles caused by this prediction |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_wpc | input | 30 | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 30 | Resolved target word address |
| upd_type | input | 2 | Branch type to store |
| mispredict_penalty | output | 4 | Constant mispredict penalty in cycles |

## Verification
The bench builds the block with its default parameters: 10 history bits, 4-bit columns and a 9-bit target buffer index. At that size the full 512-cycle sweep fits in the run, and so does saturation of the history to all ones after ten taken outcomes. Addresses come from a small pool that shares low bits but differs in tag. That pool makes target buffer aliasing and counter sharing between branches frequent. The pool also exercises the zero-extended XOR column, because different history and address pairs land on the same counter.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } gbp_state_e;

    localparam logic [1:0] CTR_WEAK_NT = 2'd1;

    // Two-bit saturating step toward the resolved outcome.
    function automatic logic [1:0] ctr_train(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) begin
            nxt = (cur == 2'd3) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == 2'd0) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gbp_ctrl.sv
module gbp_ctrl
    import gbp_pkg::*;
#(
    parameter int SWEEP_W    = 9,
    parameter int SWEEP_LAST = 511
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               in_sweep,
    output logic [SWEEP_W-1:0] sweep_idx
);

    gbp_state_e         state_q, state_d;
    logic [SWEEP_W-1:0] idx_q, idx_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_SWEEP: begin
                if (idx_q == SWEEP_W'(SWEEP_LAST)) begin
                    state_d = ST_RUN;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        sweep_idx = idx_q;
        unique case (state_q)
            ST_SWEEP: in_sweep = 1'b1;
            ST_RUN:   in_sweep = 1'b0;
        endcase
    end

endmodule

// File: rtl/gbp_history.sv
module gbp_history #(
    parameter int GHR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             outcome,
    output logic [GHR_W-1:0] ghr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ghr <= '0;
        end else if (shift_en) begin
            ghr <= {ghr[GHR_W-2:0], outcome};
        end
    end

endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
    import gbp_pkg::*;
#(
    parameter int GHR_W   = 10,
    parameter int HCOL_W  = 2,
    parameter int COL_W   = 4,
    parameter int SWEEP_W = 9
) (
    input  logic               clk,
    input  logic [GHR_W-1:0]   ghr,
    input  logic [COL_W-1:0]   rd_pc_lo,
    output logic [1:0]         rd_ctr,
    input  logic               wr_en,
    input  logic [COL_W-1:0]   wr_pc_lo,
    input  logic               wr_taken,
    input  logic               clr_en,
    input  logic [SWEEP_W-1:0] clr_idx
);

    localparam int ROW_W  = GHR_W - HCOL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int LINE_W = 2 * COLS;

    logic [LINE_W-1:0] rows_mem [ROWS];

    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  rd_col, wr_col;
    logic [LINE_W-1:0] line_cur, line_new;
    logic              clr_hit;

    // Two-dimensional index: upper history picks the row, low history
    // (zero-extended) mixed with the address picks the counter.
    always_comb begin
        row      = ghr[GHR_W-1 -: ROW_W];
        rd_col   = COL_W'(ghr[HCOL_W-1:0]) ^ rd_pc_lo;
        wr_col   = COL_W'(ghr[HCOL_W-1:0]) ^ wr_pc_lo;
        line_cur = rows_mem[row];
        rd_ctr   = line_cur[{rd_col, 1'b0} +: 2];
        line_new = line_cur;
        line_new[{wr_col, 1'b0} +: 2] = ctr_train(line_cur[{wr_col, 1'b0} +: 2], wr_taken);
        clr_hit  = {1'b0, clr_idx} < (SWEEP_W + 1)'(ROWS);
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            if (clr_hit) begin
                rows_mem[clr_idx[ROW_W-1:0]] <= {COLS{CTR_WEAK_NT}};
            end
        end else if (wr_en) begin
            rows_mem[row] <= line_new;
        end
    end

endmodule

// File: rtl/gbp_btb.sv
module gbp_btb #(
    parameter int WPC_W   = 30,
    parameter int IDX_W   = 9,
    parameter int TYPE_W  = 2,
    parameter int SWEEP_W = 9
) (
    input  logic               clk,
    input  logic [WPC_W-1:0]   rd_wpc,
    output logic               rd_hit,
    output logic [WPC_W-1:0]   rd_target,
    output logic [TYPE_W-1:0]  rd_type,
    input  logic               wr_en,
    input  logic [WPC_W-1:0]   wr_wpc,
    input  logic [WPC_W-1:0]   wr_target,
    input  logic [TYPE_W-1:0]  wr_type,
    input  logic               clr_en,
    input  logic [SWEEP_W-1:0] clr_idx
);

    localparam int TAG_W   = WPC_W - IDX_W;
    localparam int ENTRIES = 1 << IDX_W;

    logic              vld_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q [ENTRIES];
    logic [WPC_W-1:0]  tgt_q [ENTRIES];
    logic [TYPE_W-1:0] typ_q [ENTRIES];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             clr_hit;

    always_comb begin
        rd_idx    = rd_wpc[IDX_W-1:0];
        wr_idx    = wr_wpc[IDX_W-1:0];
        rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_wpc[WPC_W-1:IDX_W]);
        rd_target = rd_hit ? tgt_q[rd_idx] : '0;
        rd_type   = rd_hit ? typ_q[rd_idx] : '0;
        clr_hit   = {1'b0, clr_idx} < (SWEEP_W + 1)'(ENTRIES);
    end

    always_ff @(posedge clk) begin
        if (clr_en) begin
            if (clr_hit) begin
                vld_q[clr_idx[IDX_W-1:0]] <= 1'b0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tag_q[wr_idx] <= wr_wpc[WPC_W-1:IDX_W];
            tgt_q[wr_idx] <= wr_target;
            typ_q[wr_idx] <= wr_type;
        end
    end

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor #(
    parameter int WPC_W              = 30,
    parameter int GHR_W              = 10,
    parameter int HIST_COL_W         = 2,
    parameter int COL_W              = 4,
    parameter int BTB_IDX_W          = 9,
    parameter int TYPE_W             = 2,
    parameter int BUB_W              = 2,
    parameter int TAKEN_BUBBLES      = 1,
    parameter int PEN_W              = 4,
    parameter int MISPREDICT_PENALTY = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WPC_W-1:0]  pred_wpc,
    output logic              pred_taken,
    output logic              pred_btb_hit,
    output logic [WPC_W-1:0]  pred_target,
    output logic [TYPE_W-1:0] pred_type,
    output logic [BUB_W-1:0]  pred_bubbles,
    input  logic              upd_valid,
    input  logic [WPC_W-1:0]  upd_wpc,
    input  logic              upd_taken,
    input  logic [WPC_W-1:0]  upd_target,
    input  logic [TYPE_W-1:0] upd_type,
    output logic [PEN_W-1:0]  mispredict_penalty
);

    localparam int ROWS        = 1 << (GHR_W - HIST_COL_W);
    localparam int BTB_ENTRIES = 1 << BTB_IDX_W;
    localparam int SWEEP_N     = (ROWS > BTB_ENTRIES) ? ROWS : BTB_ENTRIES;
    localparam int SWEEP_W     = $clog2(SWEEP_N);
    localparam int SWEEP_LAST  = SWEEP_N - 1;

    logic               in_sweep;
    logic [SWEEP_W-1:0] sweep_idx;
    logic [GHR_W-1:0]   ghr;
    logic               upd_fire;
    logic [1:0]         ctr;
    logic               raw_hit;
    logic [WPC_W-1:0]   raw_target;
    logic [TYPE_W-1:0]  raw_type;

    assign upd_fire = upd_valid & ~in_sweep;

    gbp_ctrl #(
        .SWEEP_W   (SWEEP_W),
        .SWEEP_LAST(SWEEP_LAST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sweep (in_sweep),
        .sweep_idx(sweep_idx)
    );

    gbp_history #(
        .GHR_W(GHR_W)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(upd_fire),
        .outcome (upd_taken),
        .ghr     (ghr)
    );

    gbp_pht #(
        .GHR_W  (GHR_W),
        .HCOL_W (HIST_COL_W),
        .COL_W  (COL_W),
        .SWEEP_W(SWEEP_W)
    ) u_pht (
        .clk     (clk),
        .ghr     (ghr),
        .rd_pc_lo(pred_wpc[COL_W-1:0]),
        .rd_ctr  (ctr),
        .wr_en   (upd_fire),
        .wr_pc_lo(upd_wpc[COL_W-1:0]),
        .wr_taken(upd_taken),
        .clr_en  (in_sweep),
        .clr_idx (sweep_idx)
    );

    gbp_btb #(
        .WPC_W  (WPC_W),
        .IDX_W  (BTB_IDX_W),
        .TYPE_W (TYPE_W),
        .SWEEP_W(SWEEP_W)
    ) u_btb (
        .clk      (clk),
        .rd_wpc   (pred_wpc),
        .rd_hit   (raw_hit),
        .rd_target(raw_target),
        .rd_type  (raw_type),
        .wr_en    (upd_fire),
        .wr_wpc   (upd_wpc),
        .wr_target(upd_target),
        .wr_type  (upd_type),
        .clr_en   (in_sweep),
        .clr_idx  (sweep_idx)
    );

    // Prediction outputs, silenced while the tables are being cleared
    always_comb begin
        pred_btb_hit       = raw_hit & ~in_sweep;
        pred_taken         = pred_btb_hit & ctr[1];
        pred_target        = pred_btb_hit ? raw_target : '0;
        pred_type          = pred_btb_hit ? raw_type : '0;
        pred_bubbles       = pred_taken ? BUB_W'(TAKEN_BUBBLES) : '0;
        mispredict_penalty = PEN_W'(MISPREDICT_PENALTY);
    end

endmodule

// File: rtl/gbp_predictor_chk.sv
module gbp_predictor_chk #(
    parameter int GHR_W = 10,
    parameter int WPC_W = 30,
    parameter int BUB_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_sweep,
    input logic [GHR_W-1:0] ghr,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [WPC_W-1:0] upd_wpc,
    input logic [WPC_W-1:0] pred_wpc,
    input logic             pred_taken,
    input logic             pred_btb_hit,
    input logic [BUB_W-1:0] pred_bubbles
);

    AST_SWEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        in_sweep |-> (!pred_taken && !pred_btb_hit)); // R1

    AST_SWEEP_KEEPS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        in_sweep |=> $stable(ghr)); // R1

    AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !in_sweep) |=> (ghr == {$past(ghr[GHR_W-2:0]), $past(upd_taken)})); // R2

    AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(ghr)); // R2

    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_btb_hit); // R6

    AST_NO_BUBBLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> (pred_bubbles == '0)); // R7

    AST_ENTRY_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && !$past(in_sweep) && (pred_wpc == $past(upd_wpc))) |-> pred_btb_hit); // R8

endmodule

bind gbp_predictor gbp_predictor_chk #(
    .GHR_W(GHR_W),
    .WPC_W(WPC_W),
    .BUB_W(BUB_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_sweep    (in_sweep),
    .ghr         (ghr),
    .upd_valid   (upd_valid),
    .upd_taken   (upd_taken),
    .upd_wpc     (upd_wpc),
    .pred_wpc    (pred_wpc),
    .pred_taken  (pred_taken),
    .pred_btb_hit(pred_btb_hit),
    .pred_bubbles(pred_bubbles)
);

// File: tb/gbp_predictor_tb.sv
`timescale 1ns/1ps
module gbp_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] pred_wpc = '0;
    logic        pred_taken, pred_btb_hit;
    logic [29:0] pred_target;
    logic [1:0]  pred_type, pred_bubbles;
    logic        upd_valid = 1'b0;
    logic [29:0] upd_wpc = '0;
    logic        upd_taken = 1'b0;
    logic [29:0] upd_target = '0;
    logic [1:0]  upd_type = '0;
    logic [3:0]  mispredict_penalty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference state
    int          m_ctr [4096];
    bit          m_vld [512];
    int          m_tag [512];
    logic [29:0] m_tgt [512];
    logic [1:0]  m_typ [512];
    int          m_ghr;
    int          m_left;

    always #2 clk = ~clk;

    gbp_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .pred_wpc(pred_wpc),
        .pred_taken(pred_taken), .pred_btb_hit(pred_btb_hit),
        .pred_target(pred_target), .pred_type(pred_type),
        .pred_bubbles(pred_bubbles), .upd_valid(upd_valid),
        .upd_wpc(upd_wpc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_type(upd_type),
        .mispredict_penalty(mispredict_penalty)
    );

    function automatic int ctr_slot(int hist, logic [29:0] wpc);
        int r, c;
        r = (hist / 4) % 256;
        c = (hist % 4) ^ int'(wpc[3:0]);
        return r * 16 + c;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) m_ctr[i] = 1;
        for (int i = 0; i < 512; i++) m_vld[i] = 0;
        m_ghr  = 0;
        m_left = 512;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        int          e;
        bit          hit, tk;
        logic [29:0] tg;
        logic [1:0]  ty;
        e   = int'(pred_wpc) % 512;
        hit = (m_left == 0) && m_vld[e] && (m_tag[e] == int'(pred_wpc) / 512);
        tk  = hit && (m_ctr[ctr_slot(m_ghr, pred_wpc)] >= 2);
        tg  = hit ? m_tgt[e] : 30'd0;
        ty  = hit ? m_typ[e] : 2'd0;
        chk(req, "pred_btb_hit", 32'(pred_btb_hit), 32'(hit));
        chk(req, "pred_taken", 32'(pred_taken), 32'(tk));
        chk(req, "pred_target", 32'(pred_target), 32'(tg));
        chk(req, "pred_type", 32'(pred_type), 32'(ty));
        chk(req, "pred_bubbles", 32'(pred_bubbles), tk ? 32'd1 : 32'd0);
    endtask

    task automatic model_step();
        int k, e;
        if (m_left > 0) begin
            m_left--;
        end else if (upd_valid) begin
            k = ctr_slot(m_ghr, upd_wpc);
            if (upd_taken) m_ctr[k] = (m_ctr[k] < 3) ? m_ctr[k] + 1 : 3;
            else           m_ctr[k] = (m_ctr[k] > 0) ? m_ctr[k] - 1 : 0;
            e = int'(upd_wpc) % 512;
            m_vld[e] = 1;
            m_tag[e] = int'(upd_wpc) / 512;
            m_tgt[e] = upd_target;
            m_typ[e] = upd_type;
            m_ghr = ((m_ghr * 2) + (upd_taken ? 1 : 0)) % 1024;
        end
    endtask

    // Called at a falling edge with inputs already driven
    task automatic cyc(input string req);
        #1 compare(req);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input logic [29:0] up, input bit tk,
                         input logic [29:0] tg, input logic [1:0] ty, input logic [29:0] pp);
        upd_valid  = v;
        upd_wpc    = up;
        upd_taken  = tk;
        upd_target = tg;
        upd_type   = ty;
        pred_wpc   = pp;
    endtask

    function automatic logic [29:0] pool_pc();
        return 30'((($urandom_range(0, 3)) << 9) | $urandom_range(0, 7));
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        // Reset state: all prediction outputs zero (R1), penalty constant (R10)
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 30'h40, 1'b1, 30'h1234, 2'd2, 30'h40);
            #1 compare("R1");
            @(negedge clk);
        end
        chk("R10", "mispredict_penalty", 32'(mispredict_penalty), 32'd13);
        rst_n = 1'b1;

        // Sweep: updates offered every cycle must be dropped (R1)
        for (int i = 0; i < 512; i++) begin
            drive(1'b1, 30'(i % 8), 1'b1, 30'h2000 + 30'(i), 2'd1, 30'(i % 8));
            cyc("R1");
        end
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, '0, 1'b0, '0, '0, 30'(i));
            cyc("R1");
        end

        // Fill then look up; aliasing address with the same index misses (R8, R5)
        drive(1'b1, 30'h0123, 1'b0, 30'h3abc, 2'd2, 30'h0123);
        cyc("R8");
        drive(1'b0, '0, 1'b0, '0, '0, 30'h0123);
        cyc("R8");
        drive(1'b0, '0, 1'b0, '0, '0, 30'h0323);
        cyc("R5");

        // Same-cycle predict and update to one entry: old contents seen (R9)
        drive(1'b1, 30'h0123, 1'b1, 30'h1111, 2'd3, 30'h0123);
        cyc("R9");
        drive(1'b1, 30'h0323, 1'b1, 30'h2222, 2'd1, 30'h0323);
        cyc("R9");
        drive(1'b0, '0, 1'b0, '0, '0, 30'h0123);
        cyc("R5");

        // Long taken run: history saturates, counter climbs to 3 (R4, R7)
        for (int i = 0; i < 16; i++) begin
            drive(1'b1, 30'h0045, 1'b1, 30'h0777, 2'd2, 30'h0045);
            cyc("R4,R7");
        end
        // Lookup of a never-written address on the same counter (R6)
        drive(1'b0, '0, 1'b0, '0, '0, 30'h0255);
        cyc("R6");
        // Outcome patterns move the history (R2) and the column hash (R3)
        for (int i = 0; i < 40; i++) begin
            drive(1'b1, 30'h0045 + 30'(i % 3), (i % 3) != 2, 30'h0500, 2'd1, 30'h0045 + 30'(i % 5));
            cyc("R2");
        end
        for (int i = 0; i < 12; i++) begin
            drive(1'b1, 30'h0046, 1'b0, 30'h0600, 2'd0, 30'h0046);
            cyc("R4");
        end

        // Mixed traffic from a small aliasing pool (R3)
        for (int i = 0; i < 2500; i++) begin
            drive($urandom_range(0, 9) < 6, pool_pc(), $urandom_range(0, 3) != 0,
                  30'($urandom), 2'($urandom_range(0, 3)), pool_pc());
            cyc("R3");
        end
        drive(1'b0, '0, 1'b0, '0, '0, '0);
        chk("R10", "mispredict_penalty", 32'(mispredict_penalty), 32'd13);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule